// File: doc/BRIEF.md
# Streaming Binary Dot-Product Maximum Finder

The block keeps a small matrix of binary columns on chip and compares every incoming binary row against all of them at once. Each column is a 1000-bit vector. It is stored as 13 slices of 80 bits and loaded one slice at a time through a write port. A row arrives as a valid/ready stream of 80-bit beats. The first beat of a row is marked with a start flag.

For every column the block computes a binary dot product. This is the number of bit positions where both the row and the column hold a one. The sum is built beat by beat. When the last beat of a row has been taken, a pipelined comparison tree picks the largest count and the column that produced it. The result appears with a one-cycle valid strobe. A new row may begin on the very next beat.

There is no back-pressure on the result side. The input side stalls only when the write port is in use while no row is open. Once a row has started, the input is never stalled. Column writes that arrive during an open row are dropped.

Top module: `bmx_popmax`

## Requirements
- R1: For each column c, the reported count is the number of bit positions b (0 to 999) where both row bit b and column bit b are one. Row bit b travels in beat b/80 at lane b%80.
- R2: On the final beat (beat index 12), only lanes 0 to 39 count. Lanes 40 to 79 of both the row data and the stored slice have no effect on any result.
- R3: `res_max` is the largest column count and `res_idx` is the column that holds it. When several columns tie at the maximum, the lowest column index is reported.
- R4: The edge that accepts the last beat of a row is followed by exactly `$clog2(NUM_COLS)` further rising edges, after which `res_valid` is high for exactly one cycle.
- R5: A row whose first beat is accepted on the cycle after the previous row's last beat is handled correctly. Both rows produce results, in order, 13 cycles apart.
- R6: A beat accepted with `in_sof`=1 always opens a new row at beat 0 and clears all column counts. A partial row that is cut short this way produces no result.
- R7: A beat accepted with `in_sof`=0 while no row is open is discarded and has no effect.
- R8: A write stores `wr_data` into column `wr_col`, slice `wr_slice`. Bit j of the slice is column bit `wr_slice`*80+j. The write takes effect only while no row is open, and in that case `in_ready` is low in the same cycle. While a row is open, `wr_en` is ignored and `in_ready` stays high.
- R9: After reset, `res_valid` is low, no row is open, and `in_ready` is high while `wr_en` is low.
- R10: Counts are 10 bits wide and reach 1000 when a row and a column are both all ones over the 1000 meaningful bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Column slice write request |
| wr_col | input | IDX_W (3) | Column selected for the write |
| wr_slice | input | SLICE_W (4) | Slice (beat index) selected for the write |
| wr_data | input | BEAT_W (80) | Slice data |
| in_valid | input | 1 | Row beat valid |
| in_ready | output | 1 | Row beat may be taken |
| in_sof | input | 1 | Beat is the first beat of a row |
| in_data | input | BEAT_W (80) | Row beat data |
| res_valid | output | 1 | Result strobe |
| res_max | output | CNT_W (10) | Largest dot product |
| res_idx | output | IDX_W (3) | Column index of the largest dot product |

## Verification
The bench builds the block with 8 columns, 80-bit beats and 1000-bit rows. With these values the comparison tree is three levels deep, so the result latency and the tie-break are exercised through every level of the tree. The 13-beat row with a half-filled final beat puts the tail masking and the maximum count of 1000 within reach.

With only 8 columns, the whole matrix can be rewritten between rows. This lets the bench run several random matrices as well as hand-built tie, all-zero and all-one cases.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/bmx_col_store.sv
module bmx_col_store #(
  parameter int NUM_COLS  = 8,
  parameter int NUM_BEATS = 13,
  parameter int BEAT_W    = 80,
  parameter int IDX_W     = 3,
  parameter int SLICE_W   = 4
) (
  input  logic                           clk,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               wcol_i,
  input  logic [SLICE_W-1:0]             wslice_i,
  input  logic [BEAT_W-1:0]              wdata_i,
  input  logic [SLICE_W-1:0]             rbeat_i,
  output logic [NUM_COLS-1:0][BEAT_W-1:0] rd_o
);
  logic [BEAT_W-1:0] mem [NUM_COLS][NUM_BEATS];

  always_ff @(posedge clk) begin
    if (we_i) mem[wcol_i][wslice_i] <= wdata_i;
  end

  always_comb begin
    for (int c = 0; c < NUM_COLS; c++) rd_o[c] = mem[c][rbeat_i];
  end

  // R8: an accepted write lands in the addressed slice
  assert_write_lands_R8: assert property (@(posedge clk)
    we_i |=> mem[$past(wcol_i)][$past(wslice_i)] == $past(wdata_i));
endmodule

// File: rtl/bmx_col_acc.sv
module bmx_col_acc #(
  parameter int BEAT_W   = 80,
  parameter int CNT_W    = 10,
  parameter int ROW_BITS = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic              clear_i,
  input  logic [BEAT_W-1:0] row_i,
  input  logic [BEAT_W-1:0] col_i,
  output logic [CNT_W-1:0]  acc_nxt_o
);
  localparam int PC_W = $clog2(BEAT_W + 1);

  logic [CNT_W-1:0] acc_q;
  logic [PC_W-1:0]  pc;

  always_comb begin
    pc = '0;
    for (int j = 0; j < BEAT_W; j++) pc += PC_W'(row_i[j] & col_i[j]);
    acc_nxt_o = (clear_i ? '0 : acc_q) + CNT_W'(pc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (take_i) acc_q <= acc_nxt_o;
  end

  assert_acc_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= CNT_W'(ROW_BITS));
  assert_sof_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && clear_i) |=> acc_q <= CNT_W'(BEAT_W));
endmodule

// File: rtl/bmx_argmax_tree.sv
module bmx_argmax_tree #(
  parameter int NUM_COLS = 8,
  parameter int CNT_W    = 10,
  parameter int IDX_W    = 3,
  parameter int ROW_BITS = 1000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic [NUM_COLS-1:0][CNT_W-1:0] cnt_i,
  output logic                          res_valid_o,
  output logic [CNT_W-1:0]              res_max_o,
  output logic [IDX_W-1:0]              res_idx_o
);
  localparam int LEVELS = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 0;
  localparam int PAD    = 1 << LEVELS;

  logic [PAD-1:0][CNT_W-1:0] c_q [LEVELS+1];
  logic [PAD-1:0][IDX_W-1:0] i_q [LEVELS+1];
  logic [LEVELS:0]           v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int l = 0; l <= LEVELS; l++) begin
        c_q[l] <= '0;
        i_q[l] <= '0;
      end
    end else begin
      v_q[0] <= load_i;
      if (load_i) begin
        for (int i = 0; i < PAD; i++) begin
          c_q[0][i] <= (i < NUM_COLS) ? cnt_i[i] : '0;
          i_q[0][i] <= IDX_W'(i);
        end
      end
      for (int l = 1; l <= LEVELS; l++) begin
        v_q[l] <= v_q[l-1];
        for (int i = 0; i < PAD / 2; i++) begin
          if (c_q[l-1][2*i+1] > c_q[l-1][2*i]) begin
            c_q[l][i] <= c_q[l-1][2*i+1];
            i_q[l][i] <= i_q[l-1][2*i+1];
          end else begin
            c_q[l][i] <= c_q[l-1][2*i];
            i_q[l][i] <= i_q[l-1][2*i];
          end
        end
      end
    end
  end

  assign res_valid_o = v_q[LEVELS];
  assign res_max_o   = c_q[LEVELS][0];
  assign res_idx_o   = i_q[LEVELS][0];

  generate
    for (genvar l = 1; l <= LEVELS; l++) begin : g_chk
      // R3: each stage keeps the larger of its pair, lower index on a tie
      assert_pair_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
        v_q[l] |-> (c_q[l][0] >= $past(c_q[l-1][0])) &&
                   (c_q[l][0] >= $past(c_q[l-1][1])));
      assert_tie_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q[l] && $past(c_q[l-1][0]) == $past(c_q[l-1][1]))
          |-> i_q[l][0] == $past(i_q[l-1][0]));
    end
  endgenerate

  assert_max_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |-> res_max_o <= CNT_W'(ROW_BITS));
endmodule

// File: rtl/bmx_popmax.sv
module bmx_popmax #(
  parameter  int NUM_COLS  = 8,
  parameter  int BEAT_W    = 80,
  parameter  int ROW_BITS  = 1000,
  localparam int NUM_BEATS = bmx_pkg::ceil_div(ROW_BITS, BEAT_W),
  localparam int LAST_BITS = ROW_BITS - (NUM_BEATS - 1) * BEAT_W,
  localparam int CNT_W     = $clog2(ROW_BITS + 1),
  localparam int SLICE_W   = (NUM_BEATS > 1) ? $clog2(NUM_BEATS) : 1,
  localparam int IDX_W     = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_col,
  input  logic [SLICE_W-1:0] wr_slice,
  input  logic [BEAT_W-1:0]  wr_data,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_sof,
  input  logic [BEAT_W-1:0]  in_data,
  output logic               res_valid,
  output logic [CNT_W-1:0]   res_max,
  output logic [IDX_W-1:0]   res_idx
);
  localparam logic [SLICE_W-1:0] FINAL_BEAT = SLICE_W'(NUM_BEATS - 1);

  logic                           active_q;
  logic [SLICE_W-1:0]             beat_q;
  logic [SLICE_W-1:0]             cur_beat;
  logic                           take, last, store_we;
  logic [BEAT_W-1:0]              row_m;
  logic [NUM_COLS-1:0][BEAT_W-1:0] slices;
  logic [NUM_COLS-1:0][CNT_W-1:0]  acc_nxt;

  assign store_we = wr_en && !active_q &&
                    (int'(wr_slice) < NUM_BEATS) && (int'(wr_col) < NUM_COLS);
  assign in_ready = !(wr_en && !active_q);
  assign take     = in_valid && in_ready && (in_sof || active_q);
  assign cur_beat = in_sof ? '0 : beat_q;
  assign last     = take && (cur_beat == FINAL_BEAT);

  always_comb begin
    for (int j = 0; j < BEAT_W; j++)
      row_m[j] = in_data[j] && ((cur_beat != FINAL_BEAT) || (j < LAST_BITS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      beat_q   <= '0;
    end else if (take) begin
      active_q <= !last;
      beat_q   <= last ? '0 : cur_beat + 1'b1;
    end
  end

  bmx_col_store #(
    .NUM_COLS(NUM_COLS), .NUM_BEATS(NUM_BEATS), .BEAT_W(BEAT_W),
    .IDX_W(IDX_W), .SLICE_W(SLICE_W)
  ) u_store (
    .clk(clk), .we_i(store_we), .wcol_i(wr_col), .wslice_i(wr_slice),
    .wdata_i(wr_data), .rbeat_i(cur_beat), .rd_o(slices)
  );

  generate
    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
      bmx_col_acc #(.BEAT_W(BEAT_W), .CNT_W(CNT_W), .ROW_BITS(ROW_BITS)) u_acc (
        .clk(clk), .rst_n(rst_n), .take_i(take), .clear_i(in_sof),
        .row_i(row_m), .col_i(slices[c]), .acc_nxt_o(acc_nxt[c])
      );
    end
  endgenerate

  bmx_argmax_tree #(
    .NUM_COLS(NUM_COLS), .CNT_W(CNT_W), .IDX_W(IDX_W), .ROW_BITS(ROW_BITS)
  ) u_tree (
    .clk(clk), .rst_n(rst_n), .load_i(last), .cnt_i(acc_nxt),
    .res_valid_o(res_valid), .res_max_o(res_max), .res_idx_o(res_idx)
  );

  assert_beat_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    beat_q < SLICE_W'(NUM_BEATS));
  assert_open_row_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> in_ready);
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_idle_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !active_q);
endmodule

// File: tb/bmx_popmax_bench.sv
module bmx_popmax_bench;
  localparam int NC = 8, BW = 80, RB = 1000, NB = 13, LAT = 3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, in_valid = 0, in_sof = 0;
  logic [2:0] wr_col = 0;
  logic [3:0] wr_slice = 0;
  logic [BW-1:0] wr_data = 0, in_data = 0;
  logic in_ready, res_valid;
  logic [9:0] res_max;
  logic [2:0] res_idx;

  bmx_popmax u_bmx_popmax (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_col(wr_col), .wr_slice(wr_slice),
    .wr_data(wr_data), .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_data(in_data), .res_valid(res_valid), .res_max(res_max), .res_idx(res_idx)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, n_res = 0;
  int got_max [64], got_idx [64], got_cyc [64], lastc [2];
  logic [BW-1:0] colm [NC][NB];
  logic [BW-1:0] rows [2][NB];

  // seeds for random rows and columns, walked by one loop
  localparam int unsigned VEC [6][2] = '{
    '{32'h1, 32'h2}, '{32'hdead, 32'hbeef}, '{32'h1234, 32'h9876},
    '{32'hface, 32'h0ff1}, '{32'h7777, 32'h3}, '{32'haaaa, 32'h5555}};

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (res_valid && n_res < 64) begin
    got_max[n_res] = int'(res_max); got_idx[n_res] = int'(res_idx);
    got_cyc[n_res] = cyc; n_res++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp); end
  endtask

  function automatic logic [BW-1:0] rnd80(inout int unsigned st);
    logic [95:0] v;
    for (int k = 0; k < 3; k++) begin st = st * 1664525 + 1013904223; v[k*32 +: 32] = st; end
    return v[BW-1:0];
  endfunction

  task automatic exp_of(input int r, output int mx, output int ix);
    mx = -1; ix = 0;
    for (int c = 0; c < NC; c++) begin
      int cnt = 0;
      for (int b = 0; b < RB; b++) cnt += int'(rows[r][b/BW][b%BW] & colm[c][b/BW][b%BW]);
      if (cnt > mx) begin mx = cnt; ix = c; end
    end
  endtask

  task automatic load_all();
    for (int c = 0; c < NC; c++)
      for (int s = 0; s < NB; s++) begin
        @(negedge clk); wr_en = 1; wr_col = 3'(c); wr_slice = 4'(s); wr_data = colm[c][s];
        @(posedge clk);
      end
    @(negedge clk); wr_en = 0;
  endtask

  task automatic send(input int n);
    for (int r = 0; r < n; r++)
      for (int k = 0; k < NB; k++) begin
        @(negedge clk);
        if (k == 0 && r > 0) lastc[r-1] = cyc;
        in_valid = 1; in_sof = (k == 0); in_data = rows[r][k];
        @(posedge clk);
      end
    @(negedge clk); in_valid = 0; in_sof = 0; lastc[n-1] = cyc;
  endtask

  task automatic run_rows(input int n, input string req);
    int base, mx, ix;
    base = n_res;
    send(n);
    repeat (LAT + 4) @(negedge clk);
    chk(n_res == base + n, req, n_res - base, n);
    for (int r = 0; r < n && base + r < n_res; r++) begin
      exp_of(r, mx, ix);
      chk(got_max[base+r] == mx, {req, " max"}, got_max[base+r], mx);
      chk(got_idx[base+r] == ix, {req, " idx R3"}, got_idx[base+r], ix);
      chk(got_cyc[base+r] - lastc[r] == LAT, "R4 latency", got_cyc[base+r] - lastc[r], LAT);
    end
  endtask

  task automatic fill_cols(input logic [BW-1:0] v);
    for (int c = 0; c < NC; c++) for (int s = 0; s < NB; s++) colm[c][s] = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned st;
    int base;
    repeat (3) @(negedge clk);
    chk(res_valid == 0, "R9 res_valid in reset", int'(res_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(res_valid == 0, "R9 res_valid after reset", int'(res_valid), 0);
    chk(in_ready == 1, "R9 in_ready idle", int'(in_ready), 1);

    // R1: random matrices and rows from the table
    for (int v = 0; v < 6; v++) begin
      st = VEC[v][1];
      for (int c = 0; c < NC; c++) for (int s = 0; s < NB; s++) colm[c][s] = rnd80(st);
      load_all();
      st = VEC[v][0];
      for (int k = 0; k < NB; k++) rows[0][k] = rnd80(st);
      run_rows(1, "R1 random");
    end

    // R5: back-to-back rows
    st = 32'h4242;
    for (int r = 0; r < 2; r++) for (int k = 0; k < NB; k++) rows[r][k] = rnd80(st);
    run_rows(2, "R5 back-to-back");

    // R10 and R3: columns 2 and 5 all ones, others sparse, row all ones
    fill_cols('0);
    for (int s = 0; s < NB; s++) begin colm[2][s] = '1; colm[5][s] = '1; colm[0][s] = 80'h1; end
    load_all();
    for (int k = 0; k < NB; k++) rows[0][k] = '1;
    run_rows(1, "R10 full count");
    chk(got_max[n_res-1] == 1000, "R10 count 1000", got_max[n_res-1], 1000);
    chk(got_idx[n_res-1] == 2, "R3 tie lowest", got_idx[n_res-1], 2);

    // R3: all columns identical
    st = 32'h99;
    for (int s = 0; s < NB; s++) begin colm[0][s] = rnd80(st); end
    for (int c = 1; c < NC; c++) for (int s = 0; s < NB; s++) colm[c][s] = colm[0][s];
    load_all();
    run_rows(1, "R3 all tie");

    // R2: only the unused tail lanes of the final slice are set
    fill_cols('0);
    for (int c = 0; c < NC; c++) colm[c][NB-1] = {40'hff_ffff_ffff, 40'h0};
    load_all();
    run_rows(1, "R2 tail masked");
    chk(got_max[n_res-1] == 0, "R2 tail count", got_max[n_res-1], 0);

    // R7: 13 beats without start flag give no result
    base = n_res;
    for (int k = 0; k < NB; k++) begin
      @(negedge clk); in_valid = 1; in_sof = 0; in_data = '1; @(posedge clk);
    end
    @(negedge clk); in_valid = 0;
    repeat (LAT + 4) @(negedge clk);
    chk(n_res == base, "R7 stray beats dropped", n_res - base, 0);

    // R6: partial row restarted by a new start flag
    st = 32'h777;
    for (int c = 0; c < NC; c++) for (int s = 0; s < NB; s++) colm[c][s] = rnd80(st);
    load_all();
    for (int k = 0; k < NB; k++) rows[0][k] = rnd80(st);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); in_valid = 1; in_sof = (k == 0); in_data = '1; @(posedge clk);
    end
    run_rows(1, "R6 restart");

    // R8: write during an open row is ignored and does not stall input
    base = n_res;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); in_valid = 1; in_sof = (k == 0); in_data = rows[0][k]; @(posedge clk);
    end
    @(negedge clk);
    wr_en = 1; wr_col = 3'd3; wr_slice = 4'd4; wr_data = '1;
    in_data = rows[0][4]; in_sof = 0;
    #1 chk(in_ready == 1, "R8 ready mid-row", int'(in_ready), 1);
    @(posedge clk);
    for (int k = 5; k < NB; k++) begin
      @(negedge clk); in_data = rows[0][k]; @(posedge clk);
    end
    @(negedge clk); in_valid = 0; wr_en = 0; lastc[0] = cyc;
    repeat (LAT + 4) @(negedge clk);
    begin
      int mx, ix;
      exp_of(0, mx, ix);
      chk(n_res == base + 1, "R8 row result", n_res - base, 1);
      chk(got_max[n_res-1] == mx, "R8 write ignored max", got_max[n_res-1], mx);
      chk(got_idx[n_res-1] == ix, "R8 write ignored idx", got_idx[n_res-1], ix);
    end
    @(negedge clk); wr_en = 1; wr_col = 3'd3; wr_slice = 4'd0; wr_data = colm[3][0];
    #1 chk(in_ready == 0, "R8 ready low on idle write", int'(in_ready), 0);
    @(posedge clk); @(negedge clk); wr_en = 0;
    run_rows(1, "R8 store intact");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule